// File: doc/BRIEF.md
# Posted Write Buffer for On-Chip SRAM

This block sits between a CPU-side load/store port and a single-port synchronous RAM. It takes byte, halfword and word accesses on a byte-addressed bus. Each access is forced onto the naturally aligned unit that contains its address. Byte enables and lane-replicated write data come from the access size and the low address bits.

A write never goes straight to the RAM. It is parked in a one-entry holding register. The parked entry is written into the RAM only when the next write arrives, and in that same cycle the new write takes its place. A write is accepted every cycle, so back-to-back stores never wait.

Reads are served from the RAM one cycle after the request. Any lane that is still parked in the holding register is taken from there instead. A reset empties the holding register without writing it out, so the most recent write is lost unless software issued it twice.

Top module: `sram_post_wrbuf`

## Requirements
- R1: `req_size` selects the access width: 0 = byte, 1 = halfword, 2 = word, and 3 behaves exactly as a word.
- R2: A word access ignores address bits 1:0, and a halfword access ignores address bit 0. The access touches the aligned unit that contains the address.
- R3: Write lanes follow size and offset. A byte access enables lane `addr[1:0]` and takes its data from `req_wdata[7:0]`. A halfword enables 4'b0011 when `addr[1]` is 0 and 4'b1100 when it is 1, with data from `req_wdata[15:0]`. A word enables all four lanes. Lane i is `rd_data[8*i+7:8*i]`.
- R4: An accepted write is held in the buffer and is not written to the RAM while no further write arrives.
- R5: A new write commits the held entry to the RAM in the same cycle and replaces it, so consecutive writes are each accepted in one cycle with none lost.
- R6: Reset drops the held entry without committing it, so after reset the RAM shows the value from before the last write.
- R7: Writing the same data to the same location twice in a row leaves that data in the RAM across a later reset.
- R8: A read that overlaps the held entry returns the held bytes on its enabled lanes and RAM data on the other lanes.
- R9: A read request is answered on the next cycle with `rd_valid` high. `rd_data` carries the aligned word, with lanes outside the access's enables (per R3) forced to zero. While `rd_valid` is low, `rd_data` is zero, and both are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code (R1) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, right-justified |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 32 | Read result on aligned lanes |

## Verification
If the holding register kept a stale or wrong entry, the next read of that word would return wrong lanes on the very next cycle through forwarding. If the entry was committed too early or to the wrong place, the error shows only after a reset or after the entry moves on, when reading back a location exposes the RAM contents. The bench therefore mixes random traffic with resets and then reads locations whose last writes were either lost or repeated. A wrong lane enable corrupts neighbouring bytes, and the next word read of that location reveals it.

// File: rtl/spwb_pkg.sv
package spwb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;
endpackage

// File: rtl/spwb_lane_gen.sv
module spwb_lane_gen
  import spwb_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [1:0]        offset,
  input  logic [WORD_W-1:0] data_in,
  output logic [LANES-1:0]  lane_en,
  output logic [WORD_W-1:0] lane_data
);
  acc_size_e sz;
  assign sz = acc_size_e'(size);

  always_comb begin
    lane_en   = '1;
    lane_data = data_in;
    unique case (sz)
      SZ_BYTE: begin
        lane_en   = LANES'(1) << offset;
        lane_data = {LANES{data_in[LANE_W-1:0]}};
      end
      SZ_HALF: begin
        lane_en   = offset[1] ? 4'b1100 : 4'b0011;
        lane_data = {2{data_in[2*LANE_W-1:0]}};
      end
      SZ_WORD, SZ_WIDE: begin
        lane_en   = '1;
        lane_data = data_in;
      end
      default: begin
        lane_en   = '1;
        lane_data = data_in;
      end
    endcase
  end
endmodule

// File: rtl/spwb_hold_buf.sv
module spwb_hold_buf
  import spwb_pkg::*;
#(
  parameter int unsigned WA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WA_W-1:0]   in_addr,
  input  logic [WORD_W-1:0] in_data,
  input  logic [LANES-1:0]  in_be,
  output logic              held_valid,
  output logic [WA_W-1:0]   held_addr,
  output logic [WORD_W-1:0] held_data,
  output logic [LANES-1:0]  held_be
);
  logic              valid_d;
  logic [WA_W-1:0]   addr_d;
  logic [WORD_W-1:0] data_d;
  logic [LANES-1:0]  be_d;

  always_comb begin
    valid_d = held_valid;
    addr_d  = held_addr;
    data_d  = held_data;
    be_d    = held_be;
    if (load) begin
      valid_d = 1'b1;
      addr_d  = in_addr;
      data_d  = in_data;
      be_d    = in_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_addr  <= '0;
      held_data  <= '0;
      held_be    <= '0;
    end else begin
      held_valid <= valid_d;
      held_addr  <= addr_d;
      held_data  <= data_d;
      held_be    <= be_d;
    end
  end

  // R4: without a load the held entry does not move
  a_r4_entry_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(held_addr) && $stable(held_data) && $stable(held_be)));
endmodule

// File: rtl/spwb_ram.sv
module spwb_ram
  import spwb_pkg::*;
#(
  parameter int unsigned WA_W = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [WA_W-1:0]   addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << WA_W;

  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (en && we && be[i]) begin
        mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en && !we) begin
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/sram_post_wrbuf.sv
module sram_post_wrbuf
  import spwb_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);
  localparam int unsigned WA_W = ADDR_W - 2;

  logic              wr_req, rd_req, commit;
  logic [WA_W-1:0]   word_addr;
  logic [LANES-1:0]  lane_be;
  logic [WORD_W-1:0] lane_data;

  logic              held_valid;
  logic [WA_W-1:0]   held_addr;
  logic [WORD_W-1:0] held_data;
  logic [LANES-1:0]  held_be;

  logic              ram_en;
  logic [WA_W-1:0]   ram_addr;
  logic [WORD_W-1:0] ram_q;

  logic              rv_q, rv_d;
  logic [LANES-1:0]  fwd_be_q, fwd_be_d;
  logic [WORD_W-1:0] fwd_data_q, fwd_data_d;
  logic [LANES-1:0]  rmask_q, rmask_d;

  assign wr_req    = req_valid && req_write;
  assign rd_req    = req_valid && !req_write;
  assign word_addr = req_addr[ADDR_W-1:2];
  assign commit    = wr_req && held_valid;

  spwb_lane_gen u_lanes (
    .size      (req_size),
    .offset    (req_addr[1:0]),
    .data_in   (req_wdata),
    .lane_en   (lane_be),
    .lane_data (lane_data)
  );

  spwb_hold_buf #(.WA_W(WA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (wr_req),
    .in_addr    (word_addr),
    .in_data    (lane_data),
    .in_be      (lane_be),
    .held_valid (held_valid),
    .held_addr  (held_addr),
    .held_data  (held_data),
    .held_be    (held_be)
  );

  assign ram_en   = rd_req || commit;
  assign ram_addr = commit ? held_addr : word_addr;

  spwb_ram #(.WA_W(WA_W)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (commit),
    .be    (held_be),
    .addr  (ram_addr),
    .wdata (held_data),
    .rdata (ram_q)
  );

  always_comb begin
    rv_d       = rd_req;
    fwd_be_d   = fwd_be_q;
    fwd_data_d = fwd_data_q;
    rmask_d    = rmask_q;
    if (rd_req) begin
      fwd_be_d   = (held_valid && (held_addr == word_addr)) ? held_be : '0;
      fwd_data_d = held_data;
      rmask_d    = lane_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q       <= 1'b0;
      fwd_be_q   <= '0;
      fwd_data_q <= '0;
      rmask_q    <= '0;
    end else begin
      rv_q       <= rv_d;
      fwd_be_q   <= fwd_be_d;
      fwd_data_q <= fwd_data_d;
      rmask_q    <= rmask_d;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_merge
    always_comb begin
      if (!rv_q || !rmask_q[i]) begin
        rd_data[i*LANE_W +: LANE_W] = '0;
      end else if (fwd_be_q[i]) begin
        rd_data[i*LANE_W +: LANE_W] = fwd_data_q[i*LANE_W +: LANE_W];
      end else begin
        rd_data[i*LANE_W +: LANE_W] = ram_q[i*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_valid = rv_q;

  // R3: a byte access enables exactly one lane
  a_r3_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd0) |-> ($countones(lane_be) == 1));

  // R2: a halfword access enables an aligned lane pair
  a_r2_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd1) |-> (lane_be == 4'b0011 || lane_be == 4'b1100));

  // R5: every accepted write leaves a valid held entry at its word
  a_r5_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> (held_valid && held_addr == $past(word_addr)));

  // R9: a read is answered on the next cycle
  a_r9_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R9: no read, no result
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (!rd_valid && rd_data == '0));
endmodule

// File: tb/sram_post_wrbuf_tb.sv
module sram_post_wrbuf_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          rd_valid;
  logic [31:0]   rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mem_m [16];
  logic        pend_v;
  logic [3:0]  pend_a;
  logic [31:0] pend_d;
  logic [3:0]  pend_be;

  always #(CLK_P/2) clk = ~clk;

  sram_post_wrbuf #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'd0:    return 4'b0001 << off;
      2'd1:    return off[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] exp_lanes(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0:    return {4{d[7:0]}};
      2'd1:    return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] base, input logic [31:0] nd,
                                        input logic [3:0] be);
    logic [31:0] r;
    r = base;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = nd[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] visible(input logic [3:0] w);
    if (pend_v && pend_a == w) return merge(mem_m[w], pend_d, pend_be);
    return mem_m[w];
  endfunction

  function automatic logic [31:0] mask_of(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = be[i] ? 8'hFF : 8'h00;
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // drive one access at a negedge; checked at the following negedge
  task automatic op(input bit wr, input logic [1:0] sz, input logic [3:0] w,
                    input logic [1:0] off, input logic [31:0] d, input string tag);
    logic [31:0] expv;
    logic [3:0]  be;
    be   = exp_be(sz, off);
    expv = visible(w) & mask_of(be);
    req_valid = 1'b1;
    req_write = wr;
    req_size  = sz;
    req_addr  = {4'b0000, w, off};
    req_wdata = d;
    @(negedge clk);
    if (wr) begin
      if (pend_v) mem_m[pend_a] = merge(mem_m[pend_a], pend_d, pend_be);
      pend_v  = 1'b1;
      pend_a  = w;
      pend_d  = exp_lanes(sz, d);
      pend_be = be;
    end else begin
      chk(rd_valid == 1'b1, {tag, " R9 rd_valid"}, {31'd0, rd_valid}, 32'd1);
      chk(rd_data == expv, tag, rd_data, expv);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0;
    req_write = 1'b0;
    @(negedge clk);
    chk(rd_valid == 1'b0 && rd_data == 32'd0, "R9 idle output", rd_data, 32'd0);
  endtask

  task automatic do_reset();
    req_valid = 1'b0;
    rst_n     = 1'b0;
    @(negedge clk);
    rst_n  = 1'b1;
    pend_v = 1'b0;
    @(negedge clk);
    chk(rd_valid == 1'b0 && rd_data == 32'd0, "R9 reset state", rd_data, 32'd0);
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_size = 2'd0; req_addr = '0; req_wdata = '0;
    pend_v = 1'b0; pend_a = '0; pend_d = '0; pend_be = '0;
    for (int i = 0; i < 16; i++) mem_m[i] = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_valid == 1'b0 && rd_data == 32'd0, "R9 reset state", rd_data, 32'd0);

    // fill all tracked words back to back (R5), final write commits the last
    for (int i = 0; i < 16; i++) op(1'b1, 2'd2, 4'(i), 2'd0, 32'h1000_0000 + 32'(i) * 32'h0101_0101, "fill");
    op(1'b1, 2'd2, 4'd0, 2'd0, 32'h1000_0000, "fill repeat");
    for (int i = 0; i < 16; i++) op(1'b0, 2'd2, 4'(i), 2'd0, 32'h0, "R5 back-to-back fill readback");

    // R3: byte lane enable and replication
    op(1'b1, 2'd0, 4'd3, 2'd2, 32'hFFFF_FFA5, "wr");
    op(1'b0, 2'd2, 4'd3, 2'd1, 32'h0, "R3 byte at offset 2, R2 word ignores addr[1:0]");
    // R3 halfword upper half, then R8 partial forward
    op(1'b1, 2'd1, 4'd5, 2'd3, 32'h0000_BEEF, "wr");
    op(1'b0, 2'd0, 4'd5, 2'd3, 32'h0, "R8 byte read from held halfword");
    op(1'b0, 2'd2, 4'd5, 2'd0, 32'h0, "R8 word read mixes held and RAM lanes");
    op(1'b0, 2'd1, 4'd5, 2'd1, 32'h0, "R2 halfword ignores addr[0]");
    // R1: size code 3 acts as word
    op(1'b1, 2'd3, 4'd6, 2'd2, 32'hCAFE_F00D, "wr");
    op(1'b0, 2'd3, 4'd6, 2'd1, 32'h0, "R1 size 3 behaves as word");

    // R4/R6: last write lost across reset; R5: earlier one committed
    op(1'b1, 2'd2, 4'd8, 2'd0, 32'hAAAA_0001, "wr");
    op(1'b1, 2'd2, 4'd9, 2'd0, 32'hBBBB_0002, "wr");
    op(1'b1, 2'd2, 4'd8, 2'd0, 32'hAAAA_0003, "wr");
    do_reset();
    op(1'b0, 2'd2, 4'd8, 2'd0, 32'h0, "R6 held write dropped by reset, R4 not in RAM");
    op(1'b0, 2'd2, 4'd9, 2'd0, 32'h0, "R5 prior entry committed by next write");

    // R7: repeated write survives reset
    op(1'b1, 2'd1, 4'd10, 2'd0, 32'h0000_7777, "wr");
    op(1'b1, 2'd1, 4'd10, 2'd0, 32'h0000_7777, "wr");
    do_reset();
    op(1'b0, 2'd2, 4'd10, 2'd0, 32'h0, "R7 repeated write kept across reset");
    idle();

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 2) do_reset();
      else if (r < 6) idle();
      else op(($urandom % 2) == 1, 2'($urandom % 4), 4'($urandom % 16),
              2'($urandom % 4), $urandom, "R8 random read vs model");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule